// File: doc/BRIEF.md
# Ethernet MAC control register bank

This block is the control and status register file of a gigabit Ethernet MAC that has a DMA engine. It decodes an 8 KiB byte window on a simple single-cycle read/write bus and accepts only aligned 32-bit words. It holds the MAC configuration words, four station-address pairs, the DMA bus-mode, base-address, control, status and interrupt-enable words, and a few timestamp-unit control words. Identification words (version, hardware feature) are constants. The live counters and pointers owned by other units read as zero here, and writes to them are dropped.

The DMA engine reports events as one-cycle pulses on `dma_evt`. Each pulse sets the matching status bit. Software clears status bits by writing ones. Two sticky summary bits collect the pending status bits that are enabled, one for the normal group and one for the abnormal group. The summary bits that are themselves enabled drive one level-sensitive interrupt. A self-clearing software-reset bit in the bus-mode word returns the whole bank to its cold values. The station address of slot 0 is exported as a 48-bit vector for the frame path. The MDIO register pair (offsets 0x10 and 0x14) belongs to a separate block and is not decoded here.

Top module: `eth_csr_bank`

## Requirements
- R1: After hardware reset, reads return these values: 0x00001032 at 0x0020 (version), 0x100D4F37 at 0x1058 (hardware feature), 0x03E80000 at 0x0034, 0x8000FFFF at 0x0040, 0x0000FFFF at 0x0048, 0x0050 and 0x0058, 0xFFFFFFFF at 0x0044, 0x004C, 0x0054 and 0x005C, 0x00002000 at 0x0700, and 0x00020100 at 0x1000 (bus mode, bit 0 already clear). Every other word reads 0. After reset `irq` and `wr_err` are low.
- R2: A read presented in one cycle gives `rd_valid` high with `rd_data` in the next cycle. An access whose `req_addr[1:0]` is not 0 changes no state and reads 0. An unmapped offset, including 0x0010 and 0x0014, reads 0 and ignores writes.
- R3: A write to 0x1000 with bit 0 set reloads every register, including DMA status and the summary bits, with its R1 value on the next cycle. Bit 0 then reads 0, and `irq` goes low.
- R4: Writes to these offsets have no effect: 0x0020, 0x0038, 0x00D8, 0x0708, 0x070C, 0x1020, 0x1048, 0x104C, 0x1050, 0x1054 and 0x1058. The poll-demand words at 0x1004 and 0x1008 always read 0 and store nothing.
- R5: `station_addr[47:32]` equals bits 15:0 of word 0x0040, with address byte 0 in [47:40]. `station_addr[31:0]` equals word 0x0044, with byte 2 in [31:24] and byte 5 in [7:0].
- R6: In DMA status (0x1014), a pulse on `dma_evt[i]` sets status bit i for i in {0..10, 13}. Event inputs 11 and 12 are ignored. Writing 1 to a status bit clears it. The normal summary (bit 16) is set when (enable & status) has any of bits 0, 2 or 6. The abnormal summary (bit 15) is set when (enable & status) has any of bits 1, 3, 4, 5, 7, 8, 9, 10 or 13. Both summary bits stay set until cleared. A cleared summary bit sets again at once if its cause is still pending and enabled.
- R7: `irq` is high exactly when status and the enable word (0x101C) both have bit 16 set, or both have bit 15 set.
- R8: Status bits 11, 12, 14 and 17..31 are read-only and read 0. A status write with a 1 in any of those positions leaves them 0 and raises `wr_err` for exactly the following cycle.
- R9: The other decoded words (for example 0x0000, 0x100C, 0x1000 without bit 0, and 0x101C) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| dma_evt | input | 14 | One-cycle event pulses from the DMA engine |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt |
| wr_err | output | 1 | One-cycle flag: a write tried to set read-only status bits |
| station_addr | output | 48 | Station address of slot 0 |

## Verification
A summary bit that is wrongly held or dropped shows up on `irq` on the cycle after the event or write that caused it. A corrupted status word shows up in the next status read. A soft reset that misses part of the bank leaves a stale word, and the reads issued right after the reset expose it. A wrong station-address byte lane appears on `station_addr` one cycle after the address write. A decode error aliases two offsets, and the read-back of the neighbouring offsets exposes it.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
    localparam int DATA_W = 32;
    localparam int NUM_RW = 31;

    localparam int IDX_A0H     = 11;
    localparam int IDX_A0L     = 12;
    localparam int IDX_BUSMODE = 26;
    localparam int IDX_ENA     = 30;

    localparam int NIS_POS = 16;
    localparam int AIS_POS = 15;

    localparam logic [DATA_W-1:0] NORM_MASK = 32'h0000_0045;
    localparam logic [DATA_W-1:0] ABN_MASK  = 32'h0000_27BA;
    localparam logic [DATA_W-1:0] EVT_MASK  = NORM_MASK | ABN_MASK;
    localparam logic [DATA_W-1:0] SUM_MASK  = (32'h1 << NIS_POS) | (32'h1 << AIS_POS);
    localparam logic [DATA_W-1:0] W1C_MASK  = EVT_MASK | SUM_MASK;

    localparam logic [15:0] OFF_VERSION = 16'h0020;
    localparam logic [15:0] OFF_HWFEAT  = 16'h1058;
    localparam logic [15:0] OFF_STATUS  = 16'h1014;
    localparam logic [DATA_W-1:0] VERSION_VAL = 32'h0000_1032;
    localparam logic [DATA_W-1:0] HWFEAT_VAL  = 32'h100D_4F37;

    typedef logic [NUM_RW-1:0][DATA_W-1:0] rw_bank_t;

    typedef struct packed {
        rw_bank_t          regs;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } bank_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic              err;
        logic              irq;
    } stat_state_t;

    // Byte offset of each stored read/write word
    function automatic logic [15:0] rw_offset(input int idx);
        case (idx)
            0:  return 16'h0000;
            1:  return 16'h0004;
            2:  return 16'h0008;
            3:  return 16'h000C;
            4:  return 16'h0018;
            5:  return 16'h001C;
            6:  return 16'h0028;
            7:  return 16'h002C;
            8:  return 16'h0030;
            9:  return 16'h0034;
            10: return 16'h003C;
            11: return 16'h0040;
            12: return 16'h0044;
            13: return 16'h0048;
            14: return 16'h004C;
            15: return 16'h0050;
            16: return 16'h0054;
            17: return 16'h0058;
            18: return 16'h005C;
            19: return 16'h00DC;
            20: return 16'h0700;
            21: return 16'h0704;
            22: return 16'h0710;
            23: return 16'h0714;
            24: return 16'h0718;
            25: return 16'h071C;
            26: return 16'h1000;
            27: return 16'h100C;
            28: return 16'h1010;
            29: return 16'h1018;
            30: return 16'h101C;
            default: return 16'hFFFF;
        endcase
    endfunction

    // Cold value of each stored word (bus-mode reset bit already clear)
    function automatic logic [DATA_W-1:0] rw_cold(input int idx);
        case (idx)
            9:              return 32'h03E8_0000;
            11:             return 32'h8000_FFFF;
            12, 14, 16, 18: return 32'hFFFF_FFFF;
            13, 15, 17:     return 32'h0000_FFFF;
            20:             return 32'h0000_2000;
            26:             return 32'h0002_0100;
            default:        return '0;
        endcase
    endfunction

    function automatic rw_bank_t cold_bank();
        rw_bank_t b;
        for (int i = 0; i < NUM_RW; i++) b[i] = rw_cold(i);
        return b;
    endfunction
endpackage

// File: rtl/eth_csr_decode.sv
module eth_csr_decode
    import eth_csr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_RW-1:0] rw_sel,
    output logic              st_sel,
    output logic [DATA_W-1:0] const_val
);
    logic        aligned;
    logic [15:0] byte_off;

    assign aligned  = (addr[1:0] == 2'b00);
    assign byte_off = 16'(addr);

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_rw_hit
            assign rw_sel[g] = aligned && (byte_off == rw_offset(g));
        end
    endgenerate

    assign st_sel = aligned && (byte_off == OFF_STATUS);

    always_comb begin
        const_val = '0;
        if (aligned) begin
            case (byte_off)
                OFF_VERSION: const_val = VERSION_VAL;
                OFF_HWFEAT:  const_val = HWFEAT_VAL;
                default:     const_val = '0;
            endcase
        end
    end
endmodule

// File: rtl/eth_csr_status.sv
module eth_csr_status
    import eth_csr_pkg::*;
#(
    parameter int EVT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              st_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EVT_W-1:0]  evt,
    input  logic [DATA_W-1:0] ena_d,
    output logic [DATA_W-1:0] status_q,
    output logic              err_q,
    output logic              irq_q
);
    stat_state_t       q, d;
    logic [DATA_W-1:0] evt_word;
    logic [DATA_W-1:0] clr_word;

    assign evt_word = DATA_W'(evt) & EVT_MASK;
    assign clr_word = st_wr ? (wdata & W1C_MASK) : '0;

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (soft_rst) begin
            d.status = '0;
            d.irq    = 1'b0;
        end else begin
            d.status = (q.status & ~clr_word) | evt_word;
            if (|(ena_d & d.status & NORM_MASK)) d.status[NIS_POS] = 1'b1;
            if (|(ena_d & d.status & ABN_MASK))  d.status[AIS_POS] = 1'b1;
            d.err = st_wr && (|(wdata & ~W1C_MASK));
            d.irq = |(d.status & ena_d & SUM_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status_q = q.status;
    assign err_q    = q.err;
    assign irq_q    = q.irq;
endmodule

// File: rtl/eth_csr_rdmux.sv
module eth_csr_rdmux
    import eth_csr_pkg::*;
(
    input  logic [NUM_RW-1:0] rw_sel,
    input  rw_bank_t          regs,
    input  logic              st_sel,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] const_val,
    output logic [DATA_W-1:0] rd_word
);
    always_comb begin
        rd_word = const_val;
        if (st_sel) rd_word = rd_word | status;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rw_sel[i]) rd_word = rd_word | regs[i];
        end
    end
endmodule

// File: rtl/eth_csr_bank.sv
module eth_csr_bank
    import eth_csr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int EVT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [EVT_W-1:0]  dma_evt,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              wr_err,
    output logic [47:0]       station_addr
);
    bank_state_t       q, d;
    logic [NUM_RW-1:0] rw_sel;
    logic              st_sel;
    logic [DATA_W-1:0] const_val;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] ena_d;
    logic              wr_go;
    logic              st_wr;
    logic              soft_rst;

    eth_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr      (req_addr),
        .rw_sel    (rw_sel),
        .st_sel    (st_sel),
        .const_val (const_val)
    );

    eth_csr_rdmux i_rdmux (
        .rw_sel    (rw_sel),
        .regs      (q.regs),
        .st_sel    (st_sel),
        .status    (status_q),
        .const_val (const_val),
        .rd_word   (rd_word)
    );

    assign wr_go    = req_valid && req_write;
    assign st_wr    = wr_go && st_sel;
    assign soft_rst = wr_go && rw_sel[IDX_BUSMODE] && req_wdata[0];

    always_comb begin
        d          = q;
        d.rd_valid = req_valid && !req_write;
        d.rd_data  = d.rd_valid ? rd_word : '0;
        if (soft_rst) begin
            d.regs = cold_bank();
        end else if (wr_go) begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (rw_sel[i]) d.regs[i] = req_wdata;
            end
        end
    end

    assign ena_d = d.regs[IDX_ENA];

    eth_csr_status #(.EVT_W(EVT_W)) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .st_wr    (st_wr),
        .wdata    (req_wdata),
        .evt      (dma_evt),
        .ena_d    (ena_d),
        .status_q (status_q),
        .err_q    (wr_err),
        .irq_q    (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{regs: cold_bank(), rd_data: '0, rd_valid: 1'b0};
        else        q <= d;
    end

    assign rd_valid     = q.rd_valid;
    assign rd_data      = q.rd_data;
    assign station_addr = {q.regs[IDX_A0H][15:0], q.regs[IDX_A0L]};
endmodule

// File: rtl/eth_csr_chk.sv
module eth_csr_chk
    import eth_csr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rd_valid,
    input logic              irq,
    input logic              wr_err,
    input logic [47:0]       station_addr,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] ena_q,
    input logic [DATA_W-1:0] busmode_q,
    input rw_bank_t          regs_q,
    input logic              soft_rst,
    input logic              st_wr
);
    p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    p_misaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr[1:0] != 2'b00)) |=> $stable(regs_q));

    p_swr_cold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (busmode_q == 32'h0002_0100) && (status_q == '0) &&
                     (ena_q == '0) && (station_addr == 48'hFFFF_FFFF_FFFF) && !irq);

    p_nis_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[NIS_POS] && !(st_wr && req_wdata[NIS_POS]) && !soft_rst) |=> status_q[NIS_POS]);

    p_nis_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[NIS_POS]) |-> (|(status_q & ena_q & NORM_MASK)));

    p_ais_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[AIS_POS]) |-> (|(status_q & ena_q & ABN_MASK)));

    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(status_q & ena_q & SUM_MASK)));

    p_ro_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~W1C_MASK) == '0);

    p_err_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && (|(req_wdata & ~W1C_MASK))) |=> wr_err);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_wr && (|(req_wdata & ~W1C_MASK))) |=> !wr_err);
endmodule

bind eth_csr_bank eth_csr_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rd_valid     (rd_valid),
    .irq          (irq),
    .wr_err       (wr_err),
    .station_addr (station_addr),
    .status_q     (status_q),
    .ena_q        (q.regs[IDX_ENA]),
    .busmode_q    (q.regs[IDX_BUSMODE]),
    .regs_q       (q.regs),
    .soft_rst     (soft_rst),
    .st_wr        (st_wr)
);

// File: tb/test_eth_csr_bank.sv
module test_eth_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [13:0] dma_evt = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq;
    logic        wr_err;
    logic [47:0] station_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    eth_csr_bank i_eth_csr_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .dma_evt      (dma_evt),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .irq          (irq),
        .wr_err       (wr_err),
        .station_addr (station_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: read data arrives one cycle after the request
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R2 unexpected rd_valid actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), {32'h0, rd_data}, {32'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic do_wr(input logic [15:0] a, input logic [31:0] v);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a[12:0];
        req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a[12:0];
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse(input logic [13:0] b);
        dma_evt = b;
        @(negedge clk);
        dma_evt = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", {63'h0, irq}, 64'h0);
        check("R1 wr_err after reset", {63'h0, wr_err}, 64'h0);
        check("R1 station after reset", {16'h0, station_addr}, 64'h0000_FFFF_FFFF_FFFF);
        do_rd(16'h0020, 32'h0000_1032, "R1 version");
        do_rd(16'h1058, 32'h100D_4F37, "R1 hw feature");
        do_rd(16'h0034, 32'h03E8_0000, "R1 timer ctrl");
        do_rd(16'h0040, 32'h8000_FFFF, "R1 addr0 high");
        do_rd(16'h0044, 32'hFFFF_FFFF, "R1 addr0 low");
        do_rd(16'h0058, 32'h0000_FFFF, "R1 addr3 high");
        do_rd(16'h0054, 32'hFFFF_FFFF, "R1 addr2 low");
        do_rd(16'h0700, 32'h0000_2000, "R1 ts control");
        do_rd(16'h1000, 32'h0002_0100, "R1 bus mode");
        do_rd(16'h0000, 32'h0, "R1 mac config");
        do_rd(16'h1014, 32'h0, "R1 dma status");

        // R9 read/write words
        do_wr(16'h0000, 32'h0000_C00C);
        do_rd(16'h0000, 32'h0000_C00C, "R9 mac config");
        do_wr(16'h100C, 32'h1234_5678);
        do_rd(16'h100C, 32'h1234_5678, "R9 rx base");
        do_wr(16'h1000, 32'h0000_0080);
        do_rd(16'h1000, 32'h0000_0080, "R9 bus mode no reset");

        // R4 read-only and poll-demand words
        do_wr(16'h0020, 32'hFFFF_FFFF);
        do_rd(16'h0020, 32'h0000_1032, "R4 version write ignored");
        do_wr(16'h1058, 32'h0);
        do_rd(16'h1058, 32'h100D_4F37, "R4 hw feature write ignored");
        do_wr(16'h1020, 32'hDEAD_BEEF);
        do_rd(16'h1020, 32'h0, "R4 missed counter write ignored");
        do_wr(16'h1004, 32'h0000_AAAA);
        do_rd(16'h1004, 32'h0, "R4 poll demand reads zero");

        // R2 alignment and unmapped
        do_wr(16'h0002, 32'hFFFF_FFFF);
        do_rd(16'h0000, 32'h0000_C00C, "R2 misaligned write ignored");
        do_rd(16'h0042, 32'h0, "R2 misaligned read zero");
        do_wr(16'h0100, 32'h5555_5555);
        do_rd(16'h0100, 32'h0, "R2 unmapped");
        do_wr(16'h0014, 32'h0000_1234);
        do_rd(16'h0014, 32'h0, "R2 mdio pair not decoded");

        // R5 station address
        do_wr(16'h0040, 32'h8000_1122);
        do_wr(16'h0044, 32'h3344_5566);
        check("R5 station address", {16'h0, station_addr}, 64'h0000_1122_3344_5566);

        // R6 / R7 normal group
        pulse(14'h0001);
        check("R7 irq no enable", {63'h0, irq}, 64'h0);
        do_rd(16'h1014, 32'h0000_0001, "R6 event sets bit0");
        do_wr(16'h101C, 32'h0001_0001);
        check("R7 irq after enable", {63'h0, irq}, 64'h1);
        do_rd(16'h1014, 32'h0001_0001, "R6 normal summary set");
        do_wr(16'h1014, 32'h0000_0001);
        check("R7 irq summary sticky", {63'h0, irq}, 64'h1);
        do_rd(16'h1014, 32'h0001_0000, "R6 summary sticky after cause cleared");
        do_wr(16'h1014, 32'h0001_0000);
        check("R7 irq cleared", {63'h0, irq}, 64'h0);
        do_rd(16'h1014, 32'h0, "R6 summary cleared");
        do_wr(16'h101C, 32'h0000_0001);
        pulse(14'h0001);
        check("R7 summary not enabled", {63'h0, irq}, 64'h0);
        do_rd(16'h1014, 32'h0001_0001, "R6 summary set without its enable");
        do_wr(16'h1014, 32'h0001_0001);

        // R6 / R7 abnormal group
        do_wr(16'h101C, 32'h0000_8008);
        pulse(14'h0008);
        check("R7 abnormal irq", {63'h0, irq}, 64'h1);
        do_rd(16'h1014, 32'h0000_8008, "R6 abnormal summary set");
        do_wr(16'h1014, 32'h0000_8000);
        check("R7 abnormal irq held", {63'h0, irq}, 64'h1);
        do_rd(16'h1014, 32'h0000_8008, "R6 summary re-set while pending");
        do_wr(16'h1014, 32'h0000_8008);
        check("R7 abnormal irq cleared", {63'h0, irq}, 64'h0);
        pulse(14'h0800);
        do_rd(16'h1014, 32'h0, "R6 event input 11 ignored");

        // R8 read-only status bits
        do_wr(16'h1014, 32'h0000_1000);
        check("R8 wr_err raised", {63'h0, wr_err}, 64'h1);
        @(negedge clk);
        check("R8 wr_err one cycle", {63'h0, wr_err}, 64'h0);
        do_rd(16'h1014, 32'h0, "R8 read-only bit stays zero");
        do_wr(16'h1014, 32'h0000_0004);
        check("R8 no error on clear bits", {63'h0, wr_err}, 64'h0);

        // R3 software reset
        do_wr(16'h101C, 32'h0001_0001);
        pulse(14'h0001);
        check("R3 irq before reset", {63'h0, irq}, 64'h1);
        do_wr(16'h1000, 32'h0000_0081);
        check("R3 irq after soft reset", {63'h0, irq}, 64'h0);
        check("R3 station after soft reset", {16'h0, station_addr}, 64'h0000_FFFF_FFFF_FFFF);
        do_rd(16'h1000, 32'h0002_0100, "R3 bus mode self-clear");
        do_rd(16'h0040, 32'h8000_FFFF, "R3 addr0 high cold");
        do_rd(16'h101C, 32'h0, "R3 enable cold");
        do_rd(16'h1014, 32'h0, "R3 status cold");
        do_rd(16'h0000, 32'h0, "R3 mac config cold");
        do_rd(16'h100C, 32'h0, "R3 rx base cold");
        do_rd(16'h0034, 32'h03E8_0000, "R3 timer cold");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 missing read data actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule